// File: doc/BRIEF.md
# SDRAM Column Burst and Read Latency Pipeline

This block models the column side of a synchronous DRAM device while one row is open. A decoded READ or WRITE command loads a start column and a copy of the current mode fields. From that point the block steps through the burst, presenting one array column per cycle. It keeps to the order set by the programmed length and type. Read beats are delayed by the programmed CAS latency before they are flagged as valid at the data pins.

The data mask affects reads and writes differently. On a read it turns the output drivers off two cycles later. On a write it blocks the array write in the same cycle. A burst can be cut short by a burst-stop or precharge command. It can also be replaced on any cycle by a fresh READ or WRITE. A flag marks the final beat of a burst that runs to completion. When the command asked for auto precharge, a second strobe fires on that same final beat.

Top module: `sdr_col_burst`

## Requirements
- R1: While reset is low, colRead, colWrite, dataValid, outEn, burstEnd and autoPre are all 0.
- R2: A READ (cmd=1) or WRITE (cmd=2) loads the column from `col` at the clock edge. blCode 0/1/2/3 gives 1/2/4/8 beats. In sequential mode (btIn=0) the column counts up from the start and wraps inside the block that is aligned to the burst length. In the first burst cycle colAddr equals the start column.
- R3: In interleaved mode (btIn=1) the column of beat k is the start column with its low offset bits XORed with k. The aligned-block bits are unchanged.
- R4: blCode=7 with btIn=0 is a full-page burst. It counts up modulo 512, never raises burstEnd, and runs until it is stopped or replaced.
- R5: blCode 4, 5 and 6 are reserved. blCode 7 with btIn=1 is also reserved. Each of these gives a single-beat burst.
- R6: clCode 1/2/3 selects CAS latency 1/2/3, and any other code acts as 3. dataValid is high CL-1 cycles after each cycle in which colRead is high. The latency is captured when the command is accepted.
- R7: outEn equals dataValid, except that it is forced low in any cycle that follows by two cycles a cycle in which dqm was high.
- R8: During a write burst, colWrite is high on each beat except in cycles where dqm is high in that same cycle.
- R9: When wrSingle=1, a WRITE lasts one beat whatever the length is. READs still use the programmed length.
- R10: A READ or WRITE issued while a burst is running replaces it at once. The next cycle shows beat 0 of the new burst at the new column, in the new direction.
- R11: A burst-stop (cmd=3) or precharge (cmd=4) ends column generation from the next cycle. Read beats already issued still appear on dataValid for up to CL-1 cycles afterwards.
- R12: burstEnd is high in the final beat of a burst that runs to its full length. autoPre is high with it when apIn was 1 on the command. A burst that is stopped or replaced raises neither signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command: 0 idle, 1 read, 2 write, 3 burst stop, 4 precharge |
| col | input | COL_W | Start column for read or write |
| apIn | input | 1 | Auto-precharge request carried with read or write |
| blCode | input | 3 | Burst length code |
| btIn | input | 1 | Burst type: 0 sequential, 1 interleaved |
| clCode | input | 3 | CAS latency code |
| wrSingle | input | 1 | Single-location write mode |
| dqm | input | 1 | Data mask |
| colAddr | output | COL_W | Column presented to the array |
| colRead | output | 1 | Array read of colAddr this cycle |
| colWrite | output | 1 | Unmasked array write of colAddr this cycle |
| dataValid | output | 1 | Read data is present at the pins this cycle |
| outEn | output | 1 | Output drivers enabled |
| burstEnd | output | 1 | Final beat of a completed burst |
| autoPre | output | 1 | Auto precharge due at the end of this burst |

## Verification
The embedded properties assume that the CAS latency code does not change between a read command and the last of that read's data leaving the pipeline. They also assume that dqm is driven to a known level from the start of reset. The random stimulus keeps the mode fields fixed within each segment. Before it picks new fields it issues a burst stop and several idle cycles, so every change lands on an empty pipeline. The directed cases cover interruptions at a mid-burst beat, a full-page wrap past column 511, and the reserved codes.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;
  localparam int MAX_CL_P = 3;
  localparam int CL_W = $clog2(MAX_CL_P + 1);
  localparam int DQM_LAT = 2;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_STOP  = 3'd3,
    CMD_PRECH = 3'd4
  } cmd_e;

  typedef struct packed {
    logic            load;
    logic            rdIssue;
    logic            wrIssue;
    logic            interleave;
    logic [CL_W-1:0] clSel;
  } colStrobe_t;
endpackage

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic             apIn,
  input  logic [2:0]       blCode,
  input  logic             btIn,
  input  logic [2:0]       clCode,
  input  logic             wrSingle,
  output colStrobe_t       strb,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] wrapMask,
  output logic             burstEnd,
  output logic             autoPre
);
  localparam logic [COL_W-1:0] PAGE_MASK = '1;

  cmd_e cmdE;
  logic isRw, isStop;
  logic [COL_W-1:0] nLast;
  logic nFull;
  logic [CL_W-1:0] nCl;

  logic active, fullQ, interQ, wrQ, apQ;
  logic [COL_W-1:0] beatQ, lastQ;
  logic [CL_W-1:0] clQ;

  assign cmdE   = cmd_e'(cmd);
  assign isRw   = (cmdE == CMD_READ) || (cmdE == CMD_WRITE);
  assign isStop = (cmdE == CMD_STOP) || (cmdE == CMD_PRECH);

  always_comb begin
    nLast = '0;
    nFull = 1'b0;
    if (!((cmdE == CMD_WRITE) && wrSingle)) begin
      case (blCode)
        3'd1: nLast = COL_W'(1);
        3'd2: nLast = COL_W'(3);
        3'd3: nLast = COL_W'(7);
        3'd7: if (!btIn) begin
          nFull = 1'b1;
          nLast = PAGE_MASK;
        end
        default: nLast = '0;
      endcase
    end
  end

  always_comb begin
    case (clCode)
      3'd1:    nCl = CL_W'(1);
      3'd2:    nCl = CL_W'(2);
      default: nCl = CL_W'(3);
    endcase
  end

  assign burstEnd = active && !fullQ && (beatQ == lastQ);
  assign autoPre  = burstEnd && apQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      beatQ  <= '0;
      lastQ  <= '0;
      fullQ  <= 1'b0;
      interQ <= 1'b0;
      wrQ    <= 1'b0;
      apQ    <= 1'b0;
      clQ    <= CL_W'(1);
    end else if (isRw) begin
      active <= 1'b1;
      beatQ  <= '0;
      lastQ  <= nLast;
      fullQ  <= nFull;
      interQ <= btIn;
      wrQ    <= (cmdE == CMD_WRITE);
      apQ    <= apIn;
      clQ    <= nCl;
    end else if (isStop) begin
      active <= 1'b0;
    end else if (active) begin
      if (burstEnd) active <= 1'b0;
      else          beatQ  <= beatQ + COL_W'(1);
    end
  end

  assign beat     = beatQ;
  assign wrapMask = lastQ;

  always_comb begin
    strb.load       = isRw;
    strb.rdIssue    = active && !wrQ;
    strb.wrIssue    = active && wrQ;
    strb.interleave = interQ;
    strb.clSel      = clQ;
  end

  // R11
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStop |=> !(strb.rdIssue || strb.wrIssue));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRw |=> ((beat == '0) && (strb.rdIssue || strb.wrIssue)));

  // R12
  end_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstEnd && !isRw) |=> !(strb.rdIssue || strb.wrIssue));
endmodule

// File: rtl/sdr_col_datapath.sv
module sdr_col_datapath
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strb,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrapMask,
  input  logic [COL_W-1:0] col,
  input  logic             dqm,
  output logic [COL_W-1:0] colAddr,
  output logic             colRead,
  output logic             colWrite,
  output logic             dataValid,
  output logic             outEn
);
  logic [COL_W-1:0] startQ, offs;
  logic [MAX_CL_P-1:1] rdPipe;
  logic [DQM_LAT-1:0] dqmPipe;

  always_ff @(posedge clk) begin
    if (!rstN)          startQ <= '0;
    else if (strb.load) startQ <= col;
  end

  assign offs    = strb.interleave ? (startQ ^ beat) : (startQ + beat);
  assign colAddr = (startQ & ~wrapMask) | (offs & wrapMask);
  assign colRead  = strb.rdIssue;
  assign colWrite = strb.wrIssue && !dqm;

  always_ff @(posedge clk) begin
    if (!rstN) rdPipe <= '0;
    else begin
      rdPipe[1] <= strb.rdIssue;
      for (int i = 2; i < MAX_CL_P; i++) rdPipe[i] <= rdPipe[i-1];
    end
  end

  always_comb begin
    dataValid = strb.rdIssue;
    for (int i = 1; i < MAX_CL_P; i++)
      if (strb.clSel == CL_W'(i + 1)) dataValid = rdPipe[i];
  end

  genvar g;
  generate
    for (g = 0; g < DQM_LAT; g++) begin : g_dqm
      always_ff @(posedge clk) begin
        if (!rstN) dqmPipe[g] <= 1'b0;
        else       dqmPipe[g] <= (g == 0) ? dqm : dqmPipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign outEn = dataValid && !dqmPipe[DQM_LAT-1];

  // R2
  block_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rdIssue || strb.wrIssue) && $past(strb.rdIssue || strb.wrIssue) && !$past(strb.load))
    |-> ((colAddr & ~wrapMask) == ($past(colAddr) & ~wrapMask)));

  // R6
  cl_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clSel == CL_W'(2) && dataValid) |-> $past(strb.rdIssue));

  // R7
  dqm_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> !$past(dqm, 2));
endmodule

// File: rtl/sdr_col_burst.sv
module sdr_col_burst
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic [COL_W-1:0] col,
  input  logic             apIn,
  input  logic [2:0]       blCode,
  input  logic             btIn,
  input  logic [2:0]       clCode,
  input  logic             wrSingle,
  input  logic             dqm,
  output logic [COL_W-1:0] colAddr,
  output logic             colRead,
  output logic             colWrite,
  output logic             dataValid,
  output logic             outEn,
  output logic             burstEnd,
  output logic             autoPre
);
  colStrobe_t strb;
  logic [COL_W-1:0] beat, wrapMask;

  sdr_burst_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .apIn(apIn), .blCode(blCode),
    .btIn(btIn), .clCode(clCode), .wrSingle(wrSingle), .strb(strb),
    .beat(beat), .wrapMask(wrapMask), .burstEnd(burstEnd), .autoPre(autoPre)
  );

  sdr_col_datapath #(.COL_W(COL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .beat(beat), .wrapMask(wrapMask),
    .col(col), .dqm(dqm), .colAddr(colAddr), .colRead(colRead),
    .colWrite(colWrite), .dataValid(dataValid), .outEn(outEn)
  );
endmodule

// File: tb/test_sdr_col_burst.sv
module test_sdr_col_burst;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [8:0] col = '0;
  logic apIn = 1'b0, btIn = 1'b0, wrSingle = 1'b0, dqm = 1'b0;
  logic [2:0] blCode = 3'd0, clCode = 3'd1;
  logic [8:0] colAddr;
  logic colRead, colWrite, dataValid, outEn, burstEnd, autoPre;

  int checks = 0, failures = 0;
  string phase = "R1";

  bit mAct = 0, mFull = 0, mInter = 0, mWr = 0, mAp = 0;
  int mBeat = 0, mLen = 1, mStart = 0, mCl = 1;
  bit rh1 = 0, rh2 = 0, dh1 = 0, dh2 = 0;

  always #10 clk = ~clk;

  sdr_col_burst i_sdr_col_burst (
    .clk(clk), .rstN(rstN), .cmd(cmd), .col(col), .apIn(apIn), .blCode(blCode),
    .btIn(btIn), .clCode(clCode), .wrSingle(wrSingle), .dqm(dqm),
    .colAddr(colAddr), .colRead(colRead), .colWrite(colWrite),
    .dataValid(dataValid), .outEn(outEn), .burstEnd(burstEnd), .autoPre(autoPre)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, phase, $time, got, exp);
    end
  endtask

  function automatic int expAddr();
    int base, off;
    if (mFull) return (mStart + mBeat) % 512;
    base = mStart - (mStart % mLen);
    off = mStart % mLen;
    if (mInter) off = off ^ mBeat;
    else off = (off + mBeat) % mLen;
    return base + off;
  endfunction

  task automatic checkOut();
    bit eRd, eWr, eVal, eEnd;
    eRd = mAct && !mWr;
    eWr = mAct && mWr;
    eVal = (mCl == 1) ? eRd : (mCl == 2) ? rh1 : rh2;
    eEnd = mAct && !mFull && (mBeat == mLen - 1);
    chk("R10", colRead, eRd);
    chk("R8", colWrite, eWr && !dqm);
    chk("R6", dataValid, eVal);
    chk("R7", outEn, eVal && !dh2);
    chk("R12", burstEnd, eEnd);
    chk("R12", autoPre, eEnd && mAp);
    if (mAct) chk(mFull ? "R4" : (mInter ? "R3" : "R2"), colAddr, expAddr());
  endtask

  task automatic modelStep();
    bit eRd, eEnd;
    eRd = mAct && !mWr;
    eEnd = mAct && !mFull && (mBeat == mLen - 1);
    rh2 = rh1; rh1 = eRd;
    dh2 = dh1; dh1 = dqm;
    if (cmd == 3'd1 || cmd == 3'd2) begin
      mAct = 1; mBeat = 0; mStart = col; mWr = (cmd == 3'd2);
      mAp = apIn; mInter = btIn; mFull = 0;
      mCl = (clCode == 3'd1) ? 1 : (clCode == 3'd2) ? 2 : 3;
      if (mWr && wrSingle) mLen = 1;
      else if (blCode <= 3'd3) mLen = 1 << blCode;
      else if (blCode == 3'd7 && !btIn) begin mFull = 1; mLen = 512; end
      else mLen = 1;
    end else if (cmd == 3'd3 || cmd == 3'd4) mAct = 0;
    else if (mAct) begin
      if (eEnd) mAct = 0;
      else mBeat = (mBeat + 1) % 512;
    end
  endtask

  task automatic cyc(input logic [2:0] c, input int cl, input bit ap, input bit dm);
    @(negedge clk);
    cmd = c; col = 9'(cl); apIn = ap; dqm = dm;
    #1;
    checkOut();
    modelStep();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 0, 0, 0);
  endtask

  task automatic setMode(input logic [2:0] bl, input bit bt, input logic [2:0] cl, input bit ws);
    blCode = bl; btIn = bt; clCode = cl; wrSingle = ws;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0C01));
    repeat (3) @(posedge clk);
    @(negedge clk);
    phase = "R1";
    chk("R1", colRead, 0); chk("R1", colWrite, 0); chk("R1", dataValid, 0);
    chk("R1", outEn, 0); chk("R1", burstEnd, 0); chk("R1", autoPre, 0);
    rstN = 1'b1;
    idle(2);

    phase = "R2"; setMode(3'd3, 0, 3'd2, 0);
    cyc(3'd1, 13, 0, 0); idle(10);
    setMode(3'd2, 0, 3'd1, 0); cyc(3'd2, 6, 0, 0); idle(6);
    phase = "R3"; setMode(3'd3, 1, 3'd3, 0);
    cyc(3'd1, 21, 0, 0); idle(12);
    setMode(3'd2, 1, 3'd3, 0); cyc(3'd2, 1, 0, 0); idle(6);
    phase = "R4"; setMode(3'd7, 0, 3'd2, 0);
    cyc(3'd1, 505, 0, 0); idle(530); cyc(3'd3, 0, 0, 0); idle(5);
    phase = "R5";
    for (int b = 4; b <= 6; b++) begin
      setMode(3'(b), 0, 3'd1, 0); cyc(3'd1, 40 + b, 0, 0); idle(4);
    end
    setMode(3'd7, 1, 3'd1, 0); cyc(3'd1, 77, 0, 0); idle(4);
    phase = "R6";
    for (int c = 0; c < 8; c++) begin
      setMode(3'd2, 0, 3'(c), 0); cyc(3'd1, 8 * c, 0, 0); idle(8);
    end
    phase = "R7"; setMode(3'd3, 0, 3'd2, 0);
    cyc(3'd1, 100, 0, 0); cyc(3'd0, 0, 0, 1); cyc(3'd0, 0, 0, 0);
    cyc(3'd0, 0, 0, 1); cyc(3'd0, 0, 0, 1); idle(8);
    phase = "R8"; cyc(3'd2, 200, 0, 0); cyc(3'd0, 0, 0, 1); cyc(3'd0, 0, 0, 0);
    cyc(3'd0, 0, 0, 1); idle(8);
    phase = "R9"; setMode(3'd3, 0, 3'd3, 1);
    cyc(3'd2, 50, 0, 0); idle(4); cyc(3'd1, 50, 0, 0); idle(12);
    phase = "R10"; setMode(3'd3, 0, 3'd3, 0);
    cyc(3'd1, 300, 0, 0); idle(2); cyc(3'd2, 410, 1, 0); cyc(3'd1, 7, 0, 0); idle(12);
    phase = "R11";
    cyc(3'd1, 64, 1, 0); idle(3); cyc(3'd4, 0, 0, 0); idle(5);
    setMode(3'd7, 0, 3'd2, 0); cyc(3'd1, 3, 0, 0); idle(4); cyc(3'd3, 0, 0, 0); idle(5);
    phase = "R12"; setMode(3'd2, 0, 3'd1, 0);
    cyc(3'd1, 90, 1, 0); idle(6); cyc(3'd2, 91, 1, 0); idle(6);
    cyc(3'd1, 92, 1, 0); cyc(3'd3, 0, 0, 0); idle(5);

    phase = "random";
    for (int s = 0; s < 12; s++) begin
      setMode(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      for (int k = 0; k < 300; k++) begin
        int r;
        logic [2:0] c;
        r = $urandom_range(0, 99);
        c = (r < 60) ? 3'd0 : (r < 75) ? 3'd1 : (r < 87) ? 3'd2 : (r < 93) ? 3'd3 :
            (r < 98) ? 3'd4 : 3'd5;
        cyc(c, $urandom_range(0, 511), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      end
      cyc(3'd3, 0, 0, 0); idle(5);
    end
    summary();
  end
endmodule